// File: doc/BRIEF.md
# Byte-Accessed Modulo Timer Counter

This block is a 16-bit up-counter with a programmable wrap value. Software reaches it through an 8-bit register bus with five byte registers: a control/status byte, the two counter bytes and the two modulo bytes. The counter advances by one on each cycle where the timer-clock enable `tick` is high. On a tick where the count already equals the modulo, the counter goes back to zero and an overflow flag sets. The flag drives an interrupt request when the interrupt enable is set.

Software reads a 16-bit count coherently by reading the high byte first. That read freezes a copy of the low byte, and the next low-byte read returns the copy. Software writes a new modulo by writing the high byte first. From that write until the low byte is written, overflow signalling is held off, so a half-written modulo cannot raise a spurious flag or interrupt.

Top module: `bytemod_timer`

## Requirements
- R1: After reset the count is 0x0000, the modulo is 0xFFFF, the control/status byte reads 0x00, and `irq` is 0.
- R2: Register offsets from `BASE` are: control/status +0, count high +1, count low +2, modulo high +3, modulo low +4. The control/status bits are: bit 7 overflow flag, bit 6 interrupt enable, bit 5 stop, bit 4 count clear. Bit 4 always reads 0.
- R3: The count rises by one on each cycle with `tick` high and stop clear. While stop is set the count holds its value and is not cleared.
- R4: A tick while the count equals the modulo sends the count to 0x0000 and sets the overflow flag.
- R5: Bus writes to the count high or count low offset leave the count unchanged.
- R6: A count-high read copies the current count low byte into a buffer. The next count-low read returns the buffered byte and releases the buffer.
- R7: Further count-high reads while the buffer is held do not refresh the buffered byte.
- R8: A count-low read while no buffer is held returns the live low byte.
- R9: Writing 1 to the count clear bit sets the count to 0x0000 on that cycle, even when `tick` is high.
- R10: A modulo-high write blocks the flag from setting and forces `irq` low until the next modulo-low write.
- R11: The flag clears only when a read of the control/status byte that saw the flag set is followed by a control/status write with bit 7 at 0. Writing 1 to bit 7 never sets the flag.
- R12: `irq` is high exactly when the flag and the interrupt enable are both set and no modulo update is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable, one count per high cycle |
| rd_en | input | 1 | Bus read strobe (read side effects at the clock edge) |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle. These are the wrap to zero and the flag setting at the modulo, the count holding while stopped, the clear, the buffer holding its byte until a low read, and `irq` staying low while a modulo update is pending. Several behaviours span whole register sequences and only the bench scenarios can show them. Those are: the coherent high-then-low read across many ticks, the two-step flag clear, the ignored writes to the count bytes, and the wrap period swept over a range of small modulo values.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
    localparam int OFS_CTRL   = 0;
    localparam int OFS_CNT_HI = 1;
    localparam int OFS_CNT_LO = 2;
    localparam int OFS_MOD_HI = 3;
    localparam int OFS_MOD_LO = 4;

    localparam int BIT_FLAG  = 7;
    localparam int BIT_IE    = 6;
    localparam int BIT_STOP  = 5;
    localparam int BIT_CLR   = 4;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_CNT_LO = 3'd2,
        SEL_MOD_HI = 3'd3,
        SEL_MOD_LO = 3'd4,
        SEL_NONE   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/bmt_counter.sv
module bmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             stop,
    input  logic             clr,
    input  logic [CNT_W-1:0] modv,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d = st_q;
        step = tick && !stop && !clr;
        wrap = step && (st_q.cnt == modv);
        if (clr) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/bmt_readlatch.sv
module bmt_readlatch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic [DATA_W-1:0] live_lo,
    output logic              held,
    output logic [DATA_W-1:0] lat
);
    typedef struct packed {
        logic              held;
        logic [DATA_W-1:0] lat;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_lo) begin
            st_d.held = 1'b0;
        end else if (rd_hi && !st_q.held) begin
            st_d.held = 1'b1;
            st_d.lat  = live_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.held;
    assign lat  = st_q.lat;
endmodule

// File: rtl/bmt_ctrl.sv
module bmt_ctrl
    import bmt_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ctrl,
    input  logic              wr_ctrl,
    input  logic              wr_mhi,
    input  logic              wr_mlo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap,
    output logic [CNT_W-1:0]  modv,
    output logic              flag,
    output logic              ie,
    output logic              stop,
    output logic              clr,
    output logic              inhibit,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] mod_hi;
        logic [DATA_W-1:0] mod_lo;
        logic              flag;
        logic              arm;
        logic              ie;
        logic              stop;
        logic              inhibit;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_ctrl) begin
            st_d.arm = st_q.flag;
        end
        if (wr_ctrl) begin
            st_d.ie   = wdata[BIT_IE];
            st_d.stop = wdata[BIT_STOP];
            if (st_q.arm && !wdata[BIT_FLAG]) begin
                st_d.flag = 1'b0;
            end
            st_d.arm = 1'b0;
        end
        if (wr_mhi) begin
            st_d.mod_hi  = wdata;
            st_d.inhibit = 1'b1;
        end
        if (wr_mlo) begin
            st_d.mod_lo  = wdata;
            st_d.inhibit = 1'b0;
        end
        if (wrap && !st_q.inhibit) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.mod_hi <= '1;
            st_q.mod_lo <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign modv    = {st_q.mod_hi, st_q.mod_lo};
    assign flag    = st_q.flag;
    assign ie      = st_q.ie;
    assign stop    = st_q.stop;
    assign inhibit = st_q.inhibit;
    assign clr     = wr_ctrl && wdata[BIT_CLR];
    assign irq     = st_q.flag && st_q.ie && !st_q.inhibit;
endmodule

// File: rtl/bytemod_timer.sv
module bytemod_timer
    import bmt_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter int          ADDR_W = 8,
    parameter logic [7:0]  BASE   = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ovf_flag,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    reg_sel_e          sel;
    logic [ADDR_W-1:0] ofs;
    logic [CNT_W-1:0]  cnt, modv;
    logic              wrap, flag, ie, stop, clr, inhibit, held;
    logic [DATA_W-1:0] lat;
    logic              rd_hi, rd_lo, rd_ctrl, wr_ctrl, wr_mhi, wr_mlo;

    always_comb begin
        ofs = addr - ADDR_W'(BASE);
        case (ofs)
            ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
            ADDR_W'(OFS_CNT_HI): sel = SEL_CNT_HI;
            ADDR_W'(OFS_CNT_LO): sel = SEL_CNT_LO;
            ADDR_W'(OFS_MOD_HI): sel = SEL_MOD_HI;
            ADDR_W'(OFS_MOD_LO): sel = SEL_MOD_LO;
            default:             sel = SEL_NONE;
        endcase
    end

    assign rd_ctrl = rd_en && (sel == SEL_CTRL);
    assign rd_hi   = rd_en && (sel == SEL_CNT_HI);
    assign rd_lo   = rd_en && (sel == SEL_CNT_LO);
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);
    assign wr_mhi  = wr_en && (sel == SEL_MOD_HI);
    assign wr_mlo  = wr_en && (sel == SEL_MOD_LO);

    bmt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .stop (stop),
        .clr  (clr),
        .modv (modv),
        .cnt  (cnt),
        .wrap (wrap)
    );

    bmt_readlatch #(.DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hi  (rd_hi),
        .rd_lo  (rd_lo),
        .live_lo(cnt[DATA_W-1:0]),
        .held   (held),
        .lat    (lat)
    );

    bmt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_ctrl(rd_ctrl),
        .wr_ctrl(wr_ctrl),
        .wr_mhi (wr_mhi),
        .wr_mlo (wr_mlo),
        .wdata  (wdata),
        .wrap   (wrap),
        .modv   (modv),
        .flag   (flag),
        .ie     (ie),
        .stop   (stop),
        .clr    (clr),
        .inhibit(inhibit),
        .irq    (irq)
    );

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[BIT_FLAG] = flag;
                rdata[BIT_IE]   = ie;
                rdata[BIT_STOP] = stop;
            end
            SEL_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
            SEL_CNT_LO: rdata = held ? lat : cnt[DATA_W-1:0];
            SEL_MOD_HI: rdata = modv[CNT_W-1:DATA_W];
            SEL_MOD_LO: rdata = modv[DATA_W-1:0];
            default:    rdata = '0;
        endcase
    end

    assign ovf_flag = flag;
endmodule

// File: rtl/bmt_checker.sv
module bmt_checker #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              stop,
    input logic              clr,
    input logic              wrap,
    input logic              rd_lo,
    input logic              held,
    input logic [DATA_W-1:0] lat,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  modv,
    input logic              flag,
    input logic              ie,
    input logic              inhibit,
    input logic              irq
);
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop && !clr && cnt == modv) |=> (cnt == '0));

    a_r4_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !inhibit) |=> flag);

    a_r3_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !clr) |=> $stable(cnt));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rd_lo) |=> (held && $stable(lat)));

    a_r10_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !irq);

    a_r12_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ie));
endmodule

bind bytemod_timer bmt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .stop   (stop),
    .clr    (clr),
    .wrap   (wrap),
    .rd_lo  (rd_lo),
    .held   (held),
    .lat    (lat),
    .cnt    (cnt),
    .modv   (modv),
    .flag   (flag),
    .ie     (ie),
    .inhibit(inhibit),
    .irq    (irq)
);

// File: tb/bytemod_timer_bench.sv
`timescale 1ns/1ps
module bytemod_timer_bench;
    localparam logic [7:0] A_CTRL = 8'h20, A_CHI = 8'h21, A_CLO = 8'h22,
                           A_MHI  = 8'h23, A_MLO = 8'h24;
    localparam logic [7:0] C_IE = 8'h40, C_STOP = 8'h20, C_CLR = 8'h10, C_FLAG = 8'h80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       ovf_flag, irq;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bytemod_timer u_bytemod_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    // read the status byte (arms the clear) then write control with flag bit 0
    task automatic restart(input logic [7:0] ctl);
        logic [7:0] d;
        rd(A_CTRL, d);
        wr(A_CTRL, ctl | C_CLR);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 offsets
        rd(A_CHI, d); chk("R1 cnt hi", d, 0);
        rd(A_CLO, d); chk("R1 cnt lo", d, 0);
        rd(A_MHI, d); chk("R1 mod hi", d, 8'hFF);
        rd(A_MLO, d); chk("R1 mod lo", d, 8'hFF);
        rd(A_CTRL, d); chk("R1 status", d, 0);
        chk("R1 irq", irq, 0);

        // R3 counting with wide modulo, R8 live low read
        ticks(7);
        rd(A_CLO, d); chk("R8 live lo", d, 7);
        rd(A_CLO, d); chk("R3 count", d, 7);

        // R5 writes to count bytes ignored
        wr(A_CHI, 8'h55); wr(A_CLO, 8'hAA);
        rd(A_CHI, d); chk("R5 cnt hi", d, 0);
        rd(A_CLO, d); chk("R5 cnt lo", d, 7);

        // R9 clear with tick high the same cycle
        @(negedge clk);
        addr = A_CTRL; wdata = C_CLR; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(A_CLO, d); chk("R9 clear over tick", d, 0);
        rd(A_CTRL, d); chk("R2 clear bit reads 0", d, 0);

        // R6 R7 coherent read: 300 ticks = 0x012C, then 10 more = 0x0136
        ticks(300);
        rd(A_CHI, h); chk("R6 hi", h, 8'h01);
        ticks(10);
        rd(A_CHI, h); chk("R7 hi again", h, 8'h01);
        rd(A_CLO, d); chk("R7 buffered lo not refreshed", d, 8'h2C);
        rd(A_CLO, d); chk("R6 released, live lo", d, 8'h36);

        // R3 stop holds
        wr(A_CTRL, C_STOP);
        ticks(5);
        rd(A_CLO, d); chk("R3 stop hold", d, 8'h36);
        rd(A_CTRL, d); chk("R2 stop bit", d, C_STOP);
        wr(A_CTRL, 8'h00);
        ticks(2);
        rd(A_CLO, d); chk("R3 resume", d, 8'h38);

        // R4 R12 sweep over small modulo values
        for (int m = 0; m < 10; m++) begin
            wr(A_MHI, 8'h00);
            wr(A_MLO, 8'(m));
            restart(C_IE);
            ticks(m);
            rd(A_CLO, d); chk("R4 count at modulo", d, m);
            chk("R4 no flag before wrap", ovf_flag, 0);
            ticks(1);
            rd(A_CLO, d); chk("R4 wrap to zero", d, 0);
            chk("R4 flag set", ovf_flag, 1);
            chk("R12 irq with enable", irq, 1);
            ticks(m + 1);
            rd(A_CLO, d); chk("R4 second wrap", d, 0);
        end

        // R12 enable off gates irq; R11 clear sequence (flag set now)
        rd(A_CTRL, d); chk("R2 flag bit", d, C_FLAG | C_IE);
        wr(A_CTRL, C_FLAG);   // arm consumed, writing 1 never clears
        chk("R12 irq gated by enable", irq, 0);
        chk("R11 write 1 keeps flag", ovf_flag, 1);
        wr(A_CTRL, C_IE);     // not armed: no clear
        chk("R11 unarmed write keeps flag", ovf_flag, 1);
        chk("R12 irq with enable", irq, 1);

        // R10 flag already set: irq blocked while modulo update pending
        wr(A_MHI, 8'h00);
        chk("R10 irq blocked", irq, 0);
        wr(A_MLO, 8'h03);
        chk("R10 irq back", irq, 1);

        restart(C_IE);
        chk("R11 armed clear", ovf_flag, 0);
        wr(A_CTRL, C_FLAG | C_IE);
        chk("R11 write 1 does not set", ovf_flag, 0);

        // R10 wrap during pending update sets no flag
        wr(A_MHI, 8'h00);
        ticks(4);
        rd(A_CLO, d); chk("R10 count still wraps", d, 0);
        chk("R10 flag blocked", ovf_flag, 0);
        chk("R10 irq blocked", irq, 0);
        wr(A_MLO, 8'h03);
        ticks(4);
        chk("R10 flag after release", ovf_flag, 1);
        chk("R12 irq after release", irq, 1);

        // R1 reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(A_MLO, d); chk("R1 mod lo after reset", d, 8'hFF);
        chk("R1 flag after reset", ovf_flag, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule